// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage that sits behind the OR plane of a small programmable logic array. Each cell takes one sum-of-products result and decides what reaches its pad: either the sum itself or a registered copy of it, optionally inverted. The cell drives a pad enable from its own enable product term. It also picks which of three signals returns to the array as feedback: the pad input, the register output, or the raw sum. A group of cells shares a global synchronous preset term, a global asynchronous clear term, and a clock whose source and active edge are both selectable.

All logic runs on a fast system clock. The selected source clock (the dedicated clock pin or the array clock term, optionally inverted) is sampled on that system clock, and each low-to-high transition of the result becomes a one-cycle capture strobe. There is no streaming data path, so every port is a plain level signal with no valid/ready handshake.

Top module: `omc_bank`

## Requirements
- R1: Each cell has a 4-bit configuration. Bit 0 set inverts the pad data. Bit 1 set selects the registered output, clear selects the combinatorial one. Bits [3:2] choose feedback: 00 pad input, 01 register Q, 10 OR sum, 11 reserved. This gives 12 defined configurations.
- R2: On a capture strobe, the register of every cell loads that cell's OR sum as it stands at that system clock edge.
- R3: A preset term that is high at a capture strobe sets the register to 1 at that edge; without a strobe the preset has no effect.
- R4: A high clear term forces the register to 0 at once, without waiting for a clock edge, and overrides a simultaneous preset; the register stays 0 after the clear is released until the next capture strobe.
- R5: With bit 1 clear, the pad data follows the OR sum combinatorially; with bit 1 set, it follows the register.
- R6: Inversion applies only to the pad data; register and OR-sum feedback are never inverted.
- R7: In a defined configuration the pad enable equals the cell's output-enable term.
- R8: Feedback follows its select whatever the output type and the pad enable state, so OR-sum feedback works even when the pad is disabled.
- R9: The capture strobe fires at the first system clock edge at which the selected source (the clock pin when the term select is 0, the clock term when it is 1), XOR the falling-edge select, is sampled high after having been sampled low; the source not selected has no effect.
- R10: A configuration with bits [3:2] = 11 is treated as a dedicated input: pad enable 0 and feedback from the pad input.
- R11: While reset is asserted, and immediately after it, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_pin_src | input | 1 | Dedicated clock input |
| clk_term_src | input | 1 | Clock product term from the array |
| clk_use_term | input | 1 | 1 selects the clock term as source |
| clk_falling | input | 1 | 1 makes the falling edge active |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| or_sum | input | N_CELLS | OR sum of each cell |
| oe_term | input | N_CELLS | Output-enable term of each cell |
| pad_in | input | N_CELLS | Value seen at each pad |
| cfg | input | 4*N_CELLS | Configuration, cell i at bits [4i+3:4i] |
| pad_out | output | N_CELLS | Pad data |
| pad_oe | output | N_CELLS | Pad driver enable |
| fb | output | N_CELLS | Feedback into the array |

## Verification
The bench builds the bank with N_CELLS = 2. This keeps every cell's full state space small enough to sweep all 16 configuration codes against all 16 combinations of stored value, present sum, enable term and pad input, while the second cell runs a different configuration. Having two cells shows that the cells stay independent and that the global preset, clear and clock reach all of them. Directed sequences then cover preset without a strobe, a mid-cycle clear against a pending preset, and each clock source and polarity.

// File: rtl/omc_pkg.sv
package omc_pkg;

  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    FB_PAD  = 2'b00,
    FB_REG  = 2'b01,
    FB_SUM  = 2'b10,
    FB_RSVD = 2'b11
  } fb_src_e;

  typedef struct packed {
    fb_src_e fb_src;
    logic    registered;
    logic    active_low;
  } cell_cfg_t;

  function automatic cell_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    cell_cfg_t c;
    c.fb_src     = fb_src_e'(raw[3:2]);
    c.registered = raw[1];
    c.active_low = raw[0];
    return c;
  endfunction

  function automatic logic cfg_defined(input cell_cfg_t c);
    return c.fb_src != FB_RSVD;
  endfunction

endpackage

// File: rtl/omc_clk_strobe.sv
module omc_clk_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_pin_src,
  input  logic clk_term_src,
  input  logic clk_use_term,
  input  logic clk_falling,
  output logic strobe
);

  logic src_sel;
  logic src_pol;
  logic src_prev;

  assign src_sel = clk_use_term ? clk_term_src : clk_pin_src;
  assign src_pol = src_sel ^ clk_falling;

  // Held at 1 in reset so a source already high is not mistaken for an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_prev <= 1'b1;
    else        src_prev <= src_pol;
  end

  assign strobe = src_pol & ~src_prev;

  // R9: a strobe lasts a single system cycle
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/omc_reg.sv
module omc_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic preset_term,
  input  logic clear_term,
  input  logic d,
  output logic q
);

  logic arst;
  assign arst = ~rst_n | clear_term;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)        q <= 1'b0;
    else if (strobe) q <= preset_term ? 1'b1 : d;
  end

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_term |-> !q);

  assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && preset_term && !clear_term) |=> (q || clear_term));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !preset_term && !clear_term) |=> ((q == $past(d)) || clear_term));

endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic             or_sum,
  input  logic             oe_term,
  input  logic             pad_in,
  input  logic [CFG_W-1:0] cfg,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             fb
);

  cell_cfg_t c;
  logic      defined;
  logic      q;
  logic      core;

  assign c       = decode_cfg(cfg);
  assign defined = cfg_defined(c);

  omc_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .d           (or_sum),
    .q           (q)
  );

  assign core    = c.registered ? q : or_sum;
  assign pad_out = core ^ c.active_low;
  assign pad_oe  = defined & oe_term;

  always_comb begin
    unique case (c.fb_src)
      FB_REG:  fb = q;
      FB_SUM:  fb = or_sum;
      default: fb = pad_in;
    endcase
  end

  assert_oe_follows_term_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> oe_term);

  assert_reserved_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[3:2] == 2'b11) |-> (!pad_oe && fb == pad_in));

endmodule

// File: rtl/omc_bank.sv
module omc_bank
  import omc_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_pin_src,
  input  logic                     clk_term_src,
  input  logic                     clk_use_term,
  input  logic                     clk_falling,
  input  logic                     preset_term,
  input  logic                     clear_term,
  input  logic [N_CELLS-1:0]       or_sum,
  input  logic [N_CELLS-1:0]       oe_term,
  input  logic [N_CELLS-1:0]       pad_in,
  input  logic [N_CELLS*CFG_W-1:0] cfg,
  output logic [N_CELLS-1:0]       pad_out,
  output logic [N_CELLS-1:0]       pad_oe,
  output logic [N_CELLS-1:0]       fb
);

  logic strobe;

  omc_clk_strobe u_strobe (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_pin_src  (clk_pin_src),
    .clk_term_src (clk_term_src),
    .clk_use_term (clk_use_term),
    .clk_falling  (clk_falling),
    .strobe       (strobe)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    omc_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (strobe),
      .preset_term (preset_term),
      .clear_term  (clear_term),
      .or_sum      (or_sum[i]),
      .oe_term     (oe_term[i]),
      .pad_in      (pad_in[i]),
      .cfg         (cfg[i*CFG_W +: CFG_W]),
      .pad_out     (pad_out[i]),
      .pad_oe      (pad_oe[i]),
      .fb          (fb[i])
    );
  end

endmodule

// File: tb/omc_bank_tb.sv
module omc_bank_tb;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_pin_src = 1'b0, clk_term_src = 1'b0;
  logic         clk_use_term = 1'b0, clk_falling = 1'b0;
  logic         preset_term = 1'b0, clear_term = 1'b0;
  logic [N-1:0] or_sum = '0, oe_term = '0, pad_in = '0;
  logic [4*N-1:0] cfg = '0;
  logic [N-1:0] pad_out, pad_oe, fb;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  omc_bank #(.N_CELLS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_pin_src(clk_pin_src), .clk_term_src(clk_term_src),
    .clk_use_term(clk_use_term), .clk_falling(clk_falling), .preset_term(preset_term),
    .clear_term(clear_term), .or_sum(or_sum), .oe_term(oe_term), .pad_in(pad_in),
    .cfg(cfg), .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, got, exp, $time);
    end
  endtask

  // one-cycle pulse on the dedicated clock or the clock term
  task automatic pulse(input bit use_term);
    @(negedge clk);
    if (use_term) clk_term_src = ~clk_falling; else clk_pin_src = ~clk_falling;
    @(negedge clk);
    if (use_term) clk_term_src = clk_falling; else clk_pin_src = clk_falling;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfg = {4'b0110, 4'b0110};
    repeat (2) @(negedge clk);
    #1;
    check(fb[0], 1'b0, "R11 reset fb cell0");
    check(fb[1], 1'b0, "R11 reset fb cell1");
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(pad_out[0], 1'b0, "R11 after reset pad_out");

    // R1 R2 R5 R6 R7 R8 R10 sweep
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 16; v++) begin
        logic [3:0] cf [N];
        logic a [N], b [N], oe [N], pin [N];
        cf[0] = 4'(c);      a[0] = v[0];  b[0] = v[1]; oe[0] = v[2]; pin[0] = v[3];
        cf[1] = 4'(15 - c); a[1] = ~v[0]; b[1] = v[2]; oe[1] = v[3]; pin[1] = v[1];
        @(negedge clk);
        cfg = {cf[1], cf[0]};
        or_sum = {a[1], a[0]};
        clk_pin_src = 1'b1;
        @(negedge clk);
        clk_pin_src = 1'b0;
        or_sum = {b[1], b[0]};
        oe_term = {oe[1], oe[0]};
        pad_in = {pin[1], pin[0]};
        #1;
        for (int i = 0; i < N; i++) begin
          logic defined, core, efb;
          defined = cf[i][3:2] != 2'b11;
          core = cf[i][1] ? a[i] : b[i];
          case (cf[i][3:2])
            2'b01:   efb = a[i];
            2'b10:   efb = b[i];
            default: efb = pin[i];
          endcase
          if (defined) check(pad_out[i], core ^ cf[i][0], "R1 R5 R6 pad_out");
          check(pad_oe[i], defined & oe[i], "R7 R10 pad_oe");
          check(fb[i], efb, "R2 R8 R10 feedback");
        end
      end
    end

    // R3 synchronous preset
    cfg = {4'b0110, 4'b0110};
    oe_term = '1;
    or_sum = '0;
    pulse(1'b0);
    check(fb[0], 1'b0, "R2 load zero");
    @(negedge clk); preset_term = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(fb[0], 1'b0, "R3 preset without strobe");
    pulse(1'b0);
    check(fb[0], 1'b1, "R3 preset at strobe cell0");
    check(fb[1], 1'b1, "R3 preset at strobe cell1");
    @(negedge clk); preset_term = 1'b0;

    // R4 asynchronous clear, priority over preset
    @(negedge clk); clear_term = 1'b1;
    #1;
    check(fb[0], 1'b0, "R4 immediate clear fb");
    check(pad_out[1], 1'b0, "R4 immediate clear pad_out");
    preset_term = 1'b1; or_sum = '1;
    pulse(1'b0);
    check(fb[0], 1'b0, "R4 clear beats preset");
    @(negedge clk); clear_term = 1'b0; preset_term = 1'b0;
    @(negedge clk); #1;
    check(fb[0], 1'b0, "R4 stays low after release");
    pulse(1'b0);
    check(fb[0], 1'b1, "R2 capture after clear");

    // R9 clock source and polarity
    @(negedge clk); clear_term = 1'b1;
    @(negedge clk); clear_term = 1'b0; clk_use_term = 1'b1;
    repeat (2) @(negedge clk);
    or_sum = '1;
    pulse(1'b0);
    check(fb[0], 1'b0, "R9 unselected pin ignored");
    pulse(1'b1);
    check(fb[0], 1'b1, "R9 term clock captures");
    @(negedge clk);
    clk_use_term = 1'b0; clk_falling = 1'b1; clk_pin_src = 1'b1; clk_term_src = 1'b1;
    repeat (2) @(negedge clk);
    or_sum = '0;
    pulse(1'b1);
    check(fb[0], 1'b1, "R9 unselected term ignored");
    @(negedge clk); #1;
    check(fb[0], 1'b1, "R9 no capture while pin high");
    clk_pin_src = 1'b0;
    @(negedge clk); #1;
    check(fb[0], 1'b0, "R9 falling edge captures");
    check(fb[1], 1'b0, "R9 falling edge captures cell1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule